// File: doc/BRIEF.md
# Packed RGB Minifloat Expander

This block widens a 32-bit word carrying three unsigned small floating-point colour channels into four IEEE single-precision values. Two channels use an 11-bit code (5 exponent bits over 6 mantissa bits) and one uses a 10-bit code (5 exponent bits over 5 mantissa bits). None of the codes has a sign bit. Each code is rebiased from a small-float bias of 15 to the single-precision bias of 127. An alpha channel of 1.0 is added to the output.

Small-float denormals are converted exactly in integer logic. A leading-one detector picks the new exponent and the normalising shift, so the result never depends on a flush-to-zero mode. Infinity and NaN codes keep their class and their payload bits. The stage has registered outputs. A word presented with `in_valid` high appears on the outputs one clock later with `out_valid` high.

Top module: `rgb_minifloat_expander`

## Requirements
- R1: The red code is bits 10:0 of `in_word`, green is bits 21:11 and blue is bits 31:22. In every code the exponent is the upper 5 bits and the mantissa is the lower bits (6 for red and green, 5 for blue).
- R2: For a code whose exponent e is neither 0 nor 31, the output exponent field (bits 30:23) is e+112. The code mantissa is placed at the top of bits 22:0, and the remaining bits are zero.
- R3: For a code with exponent 0 and a nonzero mantissa m of width w, the output is the exact single-precision normal value m·2^(-14-w).
- R4: A code of all zeros gives the output 0x00000000.
- R5: For a code with exponent 31, the output exponent field is 0xFF and the code mantissa is placed at the top of bits 22:0. A zero mantissa gives infinity and a nonzero mantissa gives a NaN with the same payload.
- R6: `out_alpha` is 0x3F800000 (1.0) whenever `out_valid` is high.
- R7: Bit 31 (sign) of every output is zero.
- R8: `out_valid` equals `in_valid` from the previous clock. The converted data for a word appears exactly one clock after that word is accepted.
- R9: A synchronous active-high `rst` clears `out_valid` and all data outputs to zero.
- R10: While `in_valid` is low, the data outputs hold their previous values, whatever is on `in_word`.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | `in_word` carries a word to convert |
| in_word | input | 32 | Packed three-channel small-float word |
| out_valid | output | 1 | Outputs carry a converted word |
| out_red | output | 32 | Red channel, single precision |
| out_green | output | 32 | Green channel, single precision |
| out_blue | output | 32 | Blue channel, single precision |
| out_alpha | output | 32 | Alpha channel, always 1.0 when valid |

## Verification
All four channel results and `out_valid` come from a single register stage. They are therefore due on the first rising edge after the edge that accepts the word. The bench drives each word on a falling edge and reads the outputs on the next falling edge, half a cycle after they update. The sweep covers every 11-bit code on red, a scrambled copy on green and every 10-bit code on blue. For the hold case, the bench lowers `in_valid`, changes `in_word`, and checks one falling edge later that the outputs are unchanged and `out_valid` is low.

// File: rtl/mf_pkg.sv
package mf_pkg;
  localparam int F32_W      = 32;
  localparam int F32_EXP_W  = 8;
  localparam int F32_MAN_W  = 23;
  localparam int F32_BIAS   = 127;
  localparam logic [F32_W-1:0] F32_ONE = 32'h3F80_0000;
endpackage

// File: rtl/mf_lead_one.sv
module mf_lead_one #(
  parameter int W     = 6,
  parameter int POS_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     vec,
  output logic [POS_W-1:0] pos,
  output logic             found
);
  // Highest set bit wins: later iterations override earlier ones.
  always_comb begin
    pos   = '0;
    found = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) begin
        pos   = POS_W'(i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mf_widen.sv
module mf_widen
  import mf_pkg::*;
#(
  parameter int MAN_W = 6,
  parameter int EXP_W = 5
) (
  input  logic [MAN_W+EXP_W-1:0] code,
  output logic [F32_W-1:0]       f32
);
  localparam int SMALL_BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int REBIAS     = F32_BIAS - SMALL_BIAS;
  localparam int DN_BASE    = REBIAS + 1 - MAN_W;
  localparam int PAD        = F32_MAN_W - MAN_W;
  localparam int POS_W      = (MAN_W > 1) ? $clog2(MAN_W) : 1;

  logic [EXP_W-1:0] ex;
  logic [MAN_W-1:0] mn;
  logic [POS_W-1:0] lead_pos;
  logic             lead_found;
  logic [MAN_W-1:0] frac_dn;
  logic [F32_EXP_W-1:0] exp_dn;
  logic [F32_EXP_W-1:0] exp_nm;

  assign ex = code[MAN_W+EXP_W-1:MAN_W];
  assign mn = code[MAN_W-1:0];

  mf_lead_one #(.W(MAN_W), .POS_W(POS_W)) u_lead (
    .vec   (mn),
    .pos   (lead_pos),
    .found (lead_found)
  );

  // Denormal: shift the leading one out past the top, exponent tracks its position.
  assign frac_dn = mn << (MAN_W - int'(lead_pos));
  assign exp_dn  = F32_EXP_W'(DN_BASE) + F32_EXP_W'(lead_pos);
  assign exp_nm  = F32_EXP_W'(ex) + F32_EXP_W'(REBIAS);

  always_comb begin
    f32 = '0;
    if (ex == '1)
      f32 = {1'b0, {F32_EXP_W{1'b1}}, mn, {PAD{1'b0}}};
    else if (ex != '0)
      f32 = {1'b0, exp_nm, mn, {PAD{1'b0}}};
    else if (lead_found)
      f32 = {1'b0, exp_dn, frac_dn, {PAD{1'b0}}};
  end
endmodule

// File: rtl/rgb_minifloat_expander.sv
module rgb_minifloat_expander
  import mf_pkg::*;
#(
  parameter int EXP_W   = 5,
  parameter int R_MAN_W = 6,
  parameter int G_MAN_W = 6,
  parameter int B_MAN_W = 5,
  parameter int WORD_W  = R_MAN_W + G_MAN_W + B_MAN_W + 3 * EXP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  output logic [F32_W-1:0]  out_red,
  output logic [F32_W-1:0]  out_green,
  output logic [F32_W-1:0]  out_blue,
  output logic [F32_W-1:0]  out_alpha
);
  localparam int R_W   = R_MAN_W + EXP_W;
  localparam int G_W   = G_MAN_W + EXP_W;
  localparam int B_W   = B_MAN_W + EXP_W;
  localparam int R_LSB = 0;
  localparam int G_LSB = R_LSB + R_W;
  localparam int B_LSB = G_LSB + G_W;

  logic [F32_W-1:0] red_c, green_c, blue_c;

  mf_widen #(.MAN_W(R_MAN_W), .EXP_W(EXP_W)) u_red (
    .code (in_word[R_LSB +: R_W]),
    .f32  (red_c)
  );
  mf_widen #(.MAN_W(G_MAN_W), .EXP_W(EXP_W)) u_green (
    .code (in_word[G_LSB +: G_W]),
    .f32  (green_c)
  );
  mf_widen #(.MAN_W(B_MAN_W), .EXP_W(EXP_W)) u_blue (
    .code (in_word[B_LSB +: B_W]),
    .f32  (blue_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_red   <= '0;
      out_green <= '0;
      out_blue  <= '0;
      out_alpha <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_red   <= red_c;
        out_green <= green_c;
        out_blue  <= blue_c;
        out_alpha <= F32_ONE;
      end
    end
  end
endmodule

// File: rtl/mf_expander_chk.sv
module mf_expander_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [31:0] in_word,
  input logic        out_valid,
  input logic [31:0] out_red,
  input logic [31:0] out_green,
  input logic [31:0] out_blue,
  input logic [31:0] out_alpha
);
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r8_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r6_alpha_one: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_alpha == 32'h3F80_0000);
  a_r7_no_sign: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(out_red[31] || out_green[31] || out_blue[31]));
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_red) && $stable(out_green) && $stable(out_blue));
  a_r5_red_special: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_word[10:6] == 5'h1F |=> out_red[30:23] == 8'hFF);
  a_r4_red_zero: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_word[10:0] == 11'h0 |=> out_red == 32'h0);
  a_r2_blue_normal_exp: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_word[31:27] != 5'h0 && in_word[31:27] != 5'h1F
    |=> out_blue[30:23] == {3'b000, $past(in_word[31:27])} + 8'd112);
endmodule

bind rgb_minifloat_expander mf_expander_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_word   (in_word),
  .out_valid (out_valid),
  .out_red   (out_red),
  .out_green (out_green),
  .out_blue  (out_blue),
  .out_alpha (out_alpha)
);

// File: tb/test_rgb_minifloat_expander.sv
module test_rgb_minifloat_expander;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic        out_valid;
  logic [31:0] out_red, out_green, out_blue, out_alpha;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  rgb_minifloat_expander i_rgb_minifloat_expander (
    .clk, .rst, .in_valid, .in_word,
    .out_valid, .out_red, .out_green, .out_blue, .out_alpha
  );

  // Expected single-precision bits, built from the rules by repeated doubling.
  function automatic logic [31:0] expect_f(input int code, input int mw);
    int e, m, k, fe;
    e = code >> mw;
    m = code & ((1 << mw) - 1);
    if (e == 31) return {1'b0, 8'hFF, 23'(m << (23 - mw))};
    if (e != 0)  return {1'b0, 8'(e + 112), 23'(m << (23 - mw))};
    if (m == 0)  return 32'h0;
    k = 0;
    while ((m & (1 << mw)) == 0) begin
      m = m << 1;
      k++;
    end
    fe = 113 - k;
    return {1'b0, 8'(fe), 23'((m & ((1 << mw) - 1)) << (23 - mw))};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #400000;
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] keep_r, keep_g, keep_b;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 valid", {31'b0, out_valid}, 32'h0);
    check("R9 red", out_red, 32'h0);
    check("R9 alpha", out_alpha, 32'h0);
    rst = 1'b0;

    // R1 R2 R3 R4 R5 R6 R7 R8: sweep every 11-bit code
    for (int i = 0; i < 2048; i++) begin
      logic [10:0] rc, gc;
      logic [9:0]  bc;
      rc = 11'(i);
      gc = 11'(i) ^ 11'h2D5;
      bc = 10'(i) ^ {10{i[10]}};
      in_word  = {bc, gc, rc};
      in_valid = 1'b1;
      @(negedge clk);
      check("R8 valid", {31'b0, out_valid}, 32'h1);
      check("R1 R2 R3 R4 R5 R7 red", out_red, expect_f(int'(rc), 6));
      check("R1 R2 R3 R5 R7 green", out_green, expect_f(int'(gc), 6));
      check("R1 R2 R3 R4 R5 R7 blue", out_blue, expect_f(int'(bc), 5));
      check("R6 alpha", out_alpha, 32'h3F80_0000);
    end

    // R3 corner: smallest red denormal is 2^-20
    in_word = 32'h0000_0001;
    @(negedge clk);
    check("R3 min denorm", out_red, 32'h3580_0000);
    // R5: infinity and NaN with payload on red
    in_word = 32'h0000_07C0;
    @(negedge clk);
    check("R5 inf", out_red, 32'h7F80_0000);
    in_word = 32'h0000_07C5;
    @(negedge clk);
    check("R5 nan payload", out_red, 32'h7F8A_0000);

    // R10: inputs ignored while in_valid is low
    keep_r = out_red;
    keep_g = out_green;
    keep_b = out_blue;
    in_valid = 1'b0;
    in_word  = 32'h1234_5678;
    @(negedge clk);
    check("R8 idle", {31'b0, out_valid}, 32'h0);
    check("R10 red", out_red, keep_r);
    check("R10 green", out_green, keep_g);
    check("R10 blue", out_blue, keep_b);

    // R9: reset mid-run
    in_valid = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    check("R9 rerst valid", {31'b0, out_valid}, 32'h0);
    check("R9 rerst blue", out_blue, 32'h0);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule